// File: doc/BRIEF.md
# Descriptor Ring Copy Engine Channel

This block is one copy channel. It moves payload from buffers listed on a source descriptor ring into empty buffers listed on a destination descriptor ring. Both rings and all buffers sit in a word-addressed 32-bit memory. The channel reaches that memory through a single request/acknowledge port.

Software sets up the channel through a small register file. It programs the two ring bases, the ring sizes, a per-descriptor length limit, a destination buffer capacity and a global byte-reverse enable. To hand work to the engine, software writes descriptors into memory and then moves the matching write index. The engine publishes a read index for each ring, and software uses these to take back finished entries.

Source descriptors that carry the gather flag are packed one after another into a single destination buffer. That buffer is closed by the first source descriptor without the flag, and it raises one completion.

Top module: `ce_channel`

## Requirements
- R1: After reset both read indices read 0, the error output and status bit 0 are low, no memory request is raised and neither completion pulse is high.
- R2: Descriptor i of a ring occupies words base+2i (buffer word address) and base+2i+1 (bits 15:0 byte count, bits 31:16 flags). In the flags, bit 0 is gather, bit 1 is byte reverse, and bits 15:2 are metadata.
- R3: Ring indices advance by one modulo the programmed power-of-two size, so the read index wraps to 0.
- R4: The engine starts a source descriptor only when its read index differs from the source write index. When no destination buffer is already open, it also needs the destination read and write indices to differ. Otherwise it waits.
- R5: A non-gather descriptor of n bytes copies ceil(n/4) whole words to consecutive words of the destination buffer. It then writes destination word 1 as {metadata, reverse flag, 0, total bytes}.
- R6: Gather-flagged descriptors are packed consecutively into one destination buffer. The buffer completes once, after the closing non-gather descriptor, with the summed byte count and the metadata of that closing descriptor.
- R7: The bytes taken from one source descriptor are limited to the length-limit register (address 8).
- R8: The byte total of one destination buffer never exceeds the capacity register (address 9, a multiple of 4). Data beyond the capacity is dropped, and the sticky error output and status bit 0 (address 11) are set.
- R9: Each payload word is byte-reversed when the descriptor's reverse flag or control bit 0 (address 10) is set, and the written-back reverse flag then reads 1.
- R10: The destination descriptor write-back reaches memory before the destination read index advances.
- R11: dst_done pulses once per finished destination buffer and src_done once per finished non-gather source descriptor. The two never pulse in the same cycle.
- R12: The source read index reads at address 3 and the destination read index at address 7. The write indices are written at addresses 2 and 6, and the bases and sizes at 0/1 and 4/5.
- R13: A memory request keeps its address, direction and data unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 4 | Register read address |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle per request |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| src_done | output | 1 | Non-gather source descriptor finished |
| dst_done | output | 1 | Destination buffer finished |
| err | output | 1 | Sticky capacity overflow flag |

## Verification
The bench builds the channel with a 3-bit index width and programs 4-entry rings. Six transfers are therefore enough to wrap both read indices and to fill the source ring up to its last usable slot inside one gather chain. The memory model acknowledges after a rotating number of wait states, which exercises the request-hold rule under stalls. The capacity and length registers are set low enough that truncation and the overflow flag are reached with buffers of a few words.

// File: rtl/ce_pkg.sv
package ce_pkg;
  localparam int CW     = 16;  // byte count width
  localparam int META_W = 14;  // metadata bits in the flags field
  localparam int FLG_GATHER = 0;
  localparam int FLG_SWAP   = 1;

  localparam logic [3:0] A_SRC_BASE = 4'd0;
  localparam logic [3:0] A_SRC_SIZE = 4'd1;
  localparam logic [3:0] A_SRC_WR   = 4'd2;
  localparam logic [3:0] A_SRC_RD   = 4'd3;
  localparam logic [3:0] A_DST_BASE = 4'd4;
  localparam logic [3:0] A_DST_SIZE = 4'd5;
  localparam logic [3:0] A_DST_WR   = 4'd6;
  localparam logic [3:0] A_DST_RD   = 4'd7;
  localparam logic [3:0] A_MAXLEN   = 4'd8;
  localparam logic [3:0] A_CAP      = 4'd9;
  localparam logic [3:0] A_CTRL     = 4'd10;
  localparam logic [3:0] A_STATUS   = 4'd11;

  typedef enum logic [3:0] {
    S_IDLE, S_SD0, S_SD1, S_DD0, S_CHK, S_RD, S_WR, S_SFIN, S_WB, S_DADV
  } eng_st_t;
endpackage

// File: rtl/ce_swap.sv
module ce_swap #(
  parameter int BYTES = 4
) (
  input  logic               en,
  input  logic [8*BYTES-1:0] din,
  output logic [8*BYTES-1:0] dout
);
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign dout[8*b +: 8] = en ? din[8*(BYTES-1-b) +: 8] : din[8*b +: 8];
  end
endmodule

// File: rtl/ce_regs.sv
module ce_regs
  import ce_pkg::*;
#(
  parameter int IDXW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [3:0]      waddr,
  input  logic [31:0]     wdata,
  input  logic [3:0]      raddr,
  output logic [31:0]     rdata,
  input  logic [IDXW-1:0] src_rd,
  input  logic [IDXW-1:0] dst_rd,
  input  logic            err,
  output logic [31:0]     src_base,
  output logic [31:0]     dst_base,
  output logic [IDXW-1:0] src_mask,
  output logic [IDXW-1:0] dst_mask,
  output logic [IDXW-1:0] src_wr,
  output logic [IDXW-1:0] dst_wr,
  output logic [CW-1:0]   max_len,
  output logic [CW-1:0]   dst_cap,
  output logic            swap_en
);
  logic [IDXW:0] src_size, dst_size;

  assign src_mask = IDXW'(src_size - 1'b1);
  assign dst_mask = IDXW'(dst_size - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_base <= '0; dst_base <= '0; src_size <= '0; dst_size <= '0;
      src_wr <= '0; dst_wr <= '0; max_len <= '0; dst_cap <= '0; swap_en <= 1'b0;
    end else if (we) begin
      case (waddr)
        A_SRC_BASE: src_base <= wdata;
        A_SRC_SIZE: src_size <= wdata[IDXW:0];
        A_SRC_WR:   src_wr   <= wdata[IDXW-1:0] & src_mask;
        A_DST_BASE: dst_base <= wdata;
        A_DST_SIZE: dst_size <= wdata[IDXW:0];
        A_DST_WR:   dst_wr   <= wdata[IDXW-1:0] & dst_mask;
        A_MAXLEN:   max_len  <= wdata[CW-1:0];
        A_CAP:      dst_cap  <= wdata[CW-1:0];
        A_CTRL:     swap_en  <= wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (raddr)
      A_SRC_BASE: rdata = src_base;
      A_SRC_SIZE: rdata = 32'(src_size);
      A_SRC_WR:   rdata = 32'(src_wr);
      A_SRC_RD:   rdata = 32'(src_rd);
      A_DST_BASE: rdata = dst_base;
      A_DST_SIZE: rdata = 32'(dst_size);
      A_DST_WR:   rdata = 32'(dst_wr);
      A_DST_RD:   rdata = 32'(dst_rd);
      A_MAXLEN:   rdata = 32'(max_len);
      A_CAP:      rdata = 32'(dst_cap);
      A_CTRL:     rdata = {31'd0, swap_en};
      A_STATUS:   rdata = {31'd0, err};
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/ce_engine.sv
module ce_engine
  import ce_pkg::*;
#(
  parameter int IDXW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     src_base,
  input  logic [31:0]     dst_base,
  input  logic [IDXW-1:0] src_mask,
  input  logic [IDXW-1:0] dst_mask,
  input  logic [IDXW-1:0] src_wr,
  input  logic [IDXW-1:0] dst_wr,
  input  logic [CW-1:0]   max_len,
  input  logic [CW-1:0]   dst_cap,
  input  logic            swap_en,
  output logic            mem_req,
  output logic            mem_we,
  output logic [31:0]     mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic            mem_ack,
  input  logic [31:0]     mem_rdata,
  output logic [IDXW-1:0] src_rd,
  output logic [IDXW-1:0] dst_rd,
  output logic            src_done,
  output logic            dst_done,
  output logic            err
);
  eng_st_t         st, st_n;
  logic [IDXW-1:0] srd_n, drd_n;
  logic            chain, chain_n, cswap, cswap_n, err_n;
  logic [31:0]     sbuf, sbuf_n, dbuf, dbuf_n, data_q, data_n;
  logic [CW-1:0]   soff, soff_n, doff, doff_n, left, left_n;
  logic [CW-1:0]   take, take_n, total, total_n;
  logic [CW-1:0]   flg, flg_n;
  logic [CW-1:0]   clamp, room, take_c;
  logic [CW:0]     tk_ext;
  logic [31:0]     src_desc, dst_desc, rd_swp;
  logic            lane_swap;

  assign src_desc  = src_base + 32'({src_rd, 1'b0});
  assign dst_desc  = dst_base + 32'({dst_rd, 1'b0});
  assign lane_swap = flg[FLG_SWAP] | swap_en;
  assign clamp     = (mem_rdata[CW-1:0] > max_len) ? max_len : mem_rdata[CW-1:0];
  assign room      = dst_cap - {doff[CW-3:0], 2'b00};
  assign take_c    = (clamp > room) ? room : clamp;
  assign tk_ext    = {1'b0, take_c} + (CW+1)'(3);

  ce_swap #(.BYTES(4)) u_swp (.en(lane_swap), .din(mem_rdata), .dout(rd_swp));

  always_comb begin
    st_n = st; srd_n = src_rd; drd_n = dst_rd; chain_n = chain; cswap_n = cswap;
    err_n = err; sbuf_n = sbuf; dbuf_n = dbuf; data_n = data_q; soff_n = soff;
    doff_n = doff; left_n = left; take_n = take; total_n = total; flg_n = flg;
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
    src_done = 1'b0; dst_done = 1'b0;
    unique case (st)
      S_IDLE: if (src_rd != src_wr && (chain || dst_rd != dst_wr)) st_n = S_SD0;
      S_SD0: begin
        mem_req = 1'b1; mem_addr = src_desc;
        if (mem_ack) begin sbuf_n = mem_rdata; st_n = S_SD1; end
      end
      S_SD1: begin
        mem_req = 1'b1; mem_addr = src_desc + 32'd1;
        if (mem_ack) begin
          flg_n  = mem_rdata[31:16];
          take_n = take_c;
          left_n = tk_ext[CW:2] == '0 ? '0 : CW'(tk_ext[CW:2]);
          soff_n = '0;
          if (clamp > room) err_n = 1'b1;
          st_n = chain ? S_CHK : S_DD0;
        end
      end
      S_DD0: begin
        mem_req = 1'b1; mem_addr = dst_desc;
        if (mem_ack) begin dbuf_n = mem_rdata; chain_n = 1'b1; st_n = S_CHK; end
      end
      S_CHK: st_n = (left == '0) ? S_SFIN : S_RD;
      S_RD: begin
        mem_req = 1'b1; mem_addr = sbuf + 32'(soff);
        if (mem_ack) begin data_n = rd_swp; st_n = S_WR; end
      end
      S_WR: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = dbuf + 32'(doff); mem_wdata = data_q;
        if (mem_ack) begin
          soff_n = soff + 1'b1; doff_n = doff + 1'b1; left_n = left - 1'b1; st_n = S_CHK;
        end
      end
      S_SFIN: begin
        srd_n   = (src_rd + 1'b1) & src_mask;
        total_n = total + take;
        cswap_n = cswap | lane_swap;
        if (flg[FLG_GATHER]) st_n = S_IDLE;
        else begin src_done = 1'b1; st_n = S_WB; end
      end
      S_WB: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = dst_desc + 32'd1;
        mem_wdata = {flg[CW-1:2], cswap, 1'b0, total};
        if (mem_ack) st_n = S_DADV;
      end
      S_DADV: begin
        drd_n = (dst_rd + 1'b1) & dst_mask; dst_done = 1'b1;
        chain_n = 1'b0; total_n = '0; doff_n = '0; cswap_n = 1'b0; st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; src_rd <= '0; dst_rd <= '0; chain <= 1'b0; cswap <= 1'b0;
      err <= 1'b0; sbuf <= '0; dbuf <= '0; data_q <= '0; soff <= '0; doff <= '0;
      left <= '0; take <= '0; total <= '0; flg <= '0;
    end else begin
      st <= st_n; src_rd <= srd_n; dst_rd <= drd_n; chain <= chain_n; cswap <= cswap_n;
      err <= err_n; sbuf <= sbuf_n; dbuf <= dbuf_n; data_q <= data_n; soff <= soff_n;
      doff <= doff_n; left <= left_n; take <= take_n; total <= total_n; flg <= flg_n;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R13
  AST_SRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(src_rd) |-> src_rd == (($past(src_rd) + 1'b1) & src_mask)); // R3
  AST_FILL_POSTED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DD0) |-> (dst_rd != dst_wr)); // R4
  AST_WB_BEFORE_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dst_rd) |-> $past(mem_we && mem_ack, 2)); // R10
  AST_TOTAL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    total <= dst_cap); // R8
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({src_done, dst_done})); // R11
endmodule

// File: rtl/ce_channel.sv
module ce_channel
  import ce_pkg::*;
#(
  parameter int IDXW = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_waddr,
  input  logic [31:0] reg_wdata,
  input  logic [3:0]  reg_raddr,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        src_done,
  output logic        dst_done,
  output logic        err
);
  logic [31:0]     src_base, dst_base;
  logic [IDXW-1:0] src_mask, dst_mask, src_wr, dst_wr, src_rd, dst_rd;
  logic [CW-1:0]   max_len, dst_cap;
  logic            swap_en;

  ce_regs #(.IDXW(IDXW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
    .raddr(reg_raddr), .rdata(reg_rdata), .src_rd(src_rd), .dst_rd(dst_rd), .err(err),
    .src_base(src_base), .dst_base(dst_base), .src_mask(src_mask), .dst_mask(dst_mask),
    .src_wr(src_wr), .dst_wr(dst_wr), .max_len(max_len), .dst_cap(dst_cap),
    .swap_en(swap_en)
  );

  ce_engine #(.IDXW(IDXW)) u_eng (
    .clk(clk), .rst_n(rst_n), .src_base(src_base), .dst_base(dst_base),
    .src_mask(src_mask), .dst_mask(dst_mask), .src_wr(src_wr), .dst_wr(dst_wr),
    .max_len(max_len), .dst_cap(dst_cap), .swap_en(swap_en),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .src_rd(src_rd), .dst_rd(dst_rd),
    .src_done(src_done), .dst_done(dst_done), .err(err)
  );
endmodule

// File: tb/sim_ce_channel.sv
module sim_ce_channel;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_waddr = '0, reg_raddr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, mem_ack, src_done, dst_done, err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #2 clk = ~clk;  // 250 MHz

  ce_channel #(.IDXW(3)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .src_done(src_done), .dst_done(dst_done), .err(err)
  );

  // memory model with rotating wait states and a host write port
  logic [31:0] mem [0:1023];
  logic h_we = 1'b0;
  logic [9:0] h_addr = '0;
  logic [31:0] h_data = '0;
  logic [1:0] wcnt, pat;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; wcnt <= '0; pat <= '0; mem_rdata <= '0;
    end else begin
      if (h_we) mem[h_addr] <= h_data;
      if (mem_ack) mem_ack <= 1'b0;
      else if (mem_req) begin
        if (wcnt >= pat) begin
          mem_ack <= 1'b1; wcnt <= '0; pat <= pat + 2'd1;
          if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
          mem_rdata <= mem[mem_addr[9:0]];
        end else wcnt <= wcnt + 2'd1;
      end
    end
  end

  int n_chk = 0, n_fail = 0, dst_cnt = 0, src_cnt = 0, viol = 0;
  function automatic void chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endfunction

  typedef struct { int addr; logic [31:0] data; } pay_t;
  typedef struct { int addr; logic [31:0] w1; int n; } wb_t;
  pay_t pay_q[$];
  wb_t  wb_q[$];

  // R13 monitor: pending request must hold its address
  logic pend = 1'b0;
  logic [31:0] paddr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend && !(mem_req && mem_addr == paddr)) viol++;
      pend = mem_req && !mem_ack;
      paddr = mem_addr;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && src_done) src_cnt++;
    if (rst_n && dst_done) begin
      dst_cnt++;
      if (wb_q.size() == 0) chk("R11 unexpected dst_done", 32'd1, 32'd0);
      else begin
        wb_t w = wb_q.pop_front();
        chk("R5/R6 write-back word", mem[w.addr], w.w1);
        for (int i = 0; i < w.n; i++) begin
          pay_t p = pay_q.pop_front();
          chk("R5/R6/R7/R9 payload word", mem[p.addr], p.data);
        end
      end
    end
  end

  function automatic logic [31:0] bswap(logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  task automatic hw(int a, logic [31:0] d);
    @(negedge clk); h_we = 1'b1; h_addr = 10'(a); h_data = d;
    @(negedge clk); h_we = 1'b0;
  endtask
  task automatic wr_reg(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask
  task automatic rd_reg(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_raddr = a; #1; d = reg_rdata;
  endtask

  int sw = 0, dw = 0;
  // R2 layout: descriptor i at base+2i, word1 = {flags, bytes}
  task automatic put_src(int ba, logic [15:0] nb, logic [15:0] fl);
    hw(100 + 2*sw, 32'(ba)); hw(101 + 2*sw, {fl, nb}); sw = (sw + 1) % 4;
  endtask
  task automatic go_src(); wr_reg(4'd2, 32'(sw)); endtask
  task automatic post_dst(int ba);
    hw(200 + 2*dw, 32'(ba)); hw(201 + 2*dw, 32'd0); dw = (dw + 1) % 4;
    wr_reg(4'd6, 32'(dw));
  endtask
  task automatic src_words(int sa, int n, int da, bit s);
    for (int i = 0; i < n; i++) begin
      logic [31:0] d = 32'hA100_0000 + 32'(sa*16 + i*3 + 1);
      hw(sa + i, d);
      pay_q.push_back('{da + i, s ? bswap(d) : d});
    end
  endtask
  task automatic exp_wb(int idx, logic [31:0] w1, int n);
    wb_q.push_back('{201 + 2*idx, w1, n});
  endtask
  task automatic wait_dst(int n);
    for (int c = 0; c < 3000 && dst_cnt < n; c++) @(negedge clk);
    chk("R11 completion count", 32'(dst_cnt), 32'(n));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_reg(4'd3, v); chk("R1 src rd idx", v, 0);
    rd_reg(4'd7, v); chk("R1 dst rd idx", v, 0);
    rd_reg(4'd11, v); chk("R1 status", v, 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 pulses/err", {29'd0, src_done, dst_done, err}, 0);
    // R12 register setup
    wr_reg(4'd0, 100); wr_reg(4'd1, 4); wr_reg(4'd4, 200); wr_reg(4'd5, 4);
    wr_reg(4'd8, 64); wr_reg(4'd9, 32); wr_reg(4'd10, 0);
    rd_reg(4'd5, v); chk("R12 dst size readback", v, 4);

    // R4: source posted, no destination -> waits
    src_words(300, 2, 400, 0);
    put_src(300, 16'd8, 16'h0014);
    exp_wb(0, 32'h0014_0008, 2);
    go_src();
    repeat (40) @(negedge clk);
    rd_reg(4'd3, v); chk("R4 no progress without dst", v, 0);
    chk("R4 no src_done", 32'(src_cnt), 0);
    post_dst(400);
    wait_dst(1);  // R5
    rd_reg(4'd3, v); chk("R12 src rd idx", v, 1);
    rd_reg(4'd7, v); chk("R12 dst rd idx", v, 1);

    // R6 gather chain: 4 + 6 + 4 bytes -> 1+2+1 words, one completion
    post_dst(420);
    src_words(310, 1, 420, 0); src_words(320, 2, 421, 0); src_words(330, 1, 423, 0);
    put_src(310, 16'd4, 16'h0005); put_src(320, 16'd6, 16'h0009); put_src(330, 16'd4, 16'h001C);
    exp_wb(1, 32'h001C_000E, 4);
    go_src();
    wait_dst(2);
    repeat (20) @(negedge clk);
    chk("R6 single completion", 32'(dst_cnt), 2);
    chk("R11 src_done non-gather only", 32'(src_cnt), 2);
    rd_reg(4'd3, v); chk("R3 src idx wrapped", v, 0);

    // R7 length limit
    wr_reg(4'd8, 8);
    for (int i = 0; i < 4; i++) hw(440 + i, 32'hDEAD_BEEF);
    src_words(340, 2, 440, 0); hw(342, 32'h1111_1111); hw(343, 32'h2222_2222);
    pay_q.push_back('{442, 32'hDEAD_BEEF});
    post_dst(440);
    put_src(340, 16'd16, 16'h000C);
    exp_wb(2, 32'h000C_0008, 3);
    go_src();
    wait_dst(3);
    wr_reg(4'd8, 64);

    // R9 byte reverse via descriptor flag
    src_words(350, 1, 460, 1);
    post_dst(460);
    put_src(350, 16'd4, 16'h0002);
    exp_wb(3, 32'h0002_0004, 1);
    go_src();
    wait_dst(4);
    rd_reg(4'd7, v); chk("R3 dst idx wrapped", v, 0);

    // R9 byte reverse via control bit
    wr_reg(4'd10, 1);
    src_words(360, 1, 470, 1);
    post_dst(470);
    put_src(360, 16'd4, 16'h0000);
    exp_wb(0, 32'h0002_0004, 1);
    go_src();
    wait_dst(5);
    wr_reg(4'd10, 0);
    chk("R8 no error before overflow", 32'(err), 0);

    // R8 capacity overflow: 24 + 16 bytes into 32-byte buffer
    for (int i = 0; i < 10; i++) hw(480 + i, 32'hDEAD_BEEF);
    src_words(370, 6, 480, 0); src_words(380, 2, 486, 0);
    hw(382, 32'h3333_3333); hw(383, 32'h4444_4444);
    pay_q.push_back('{488, 32'hDEAD_BEEF});
    post_dst(480);
    put_src(370, 16'd24, 16'h0001); put_src(380, 16'd16, 16'h0010);
    exp_wb(1, 32'h0010_0020, 9);
    go_src();
    wait_dst(6);
    chk("R8 err output", 32'(err), 1);
    rd_reg(4'd11, v); chk("R8 status bit", v, 1);
    chk("R11 total src_done", 32'(src_cnt), 6);
    chk("R13 request hold violations", 32'(viol), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule